// File: doc/BRIEF.md
# Asynchronous static RAM port controller

This block lets a clocked host read and write an external asynchronous static RAM of 32K words by 8 bits. The host hands over one access at a time through a valid/ready request channel. The controller then generates the active-low chip-select, output-enable and write-strobe pins and the address. It also drives the 8-bit shared data bus, which is modelled as separate out, in and driver-enable signals. Read data returns on a one-cycle response strobe.

Every phase of the memory cycle lasts a whole number of clock cycles. That number is the ceiling of a nanosecond figure from the memory's speed grade divided by the clock period, and it is never less than one cycle. Writes are controlled by the write strobe, and output-enable stays high during them, so the memory's outputs are already off when the controller turns its driver on. After each read, output-enable is high for a release phase before any further access may begin.

Back-pressure rules:
- A request transfers on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high only while the controller is idle.
- The host may hold `req_valid` high while `req_ready` is low. Nothing on the request inputs is sampled in those cycles.
- The response has no back-pressure. `resp_valid` is a single-cycle pulse that the host must take when it appears.

Top module: `sram_port_ctrl`

## Requirements
- R1: After a synchronous reset, and in every cycle where `req_ready` is high, the pins `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1 and `mem_dq_oe` is 0. A request presented while reset is asserted is never performed.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `req_ready` goes low in the next cycle and stays low until the sequence ends. Request inputs presented while `req_ready` is low have no effect on the memory.
- R3: A read (`req_write`=0) starts in the cycle after acceptance with `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD cycles. RD is the larger of the address-access and output-enable-access cycle counts.
- R4: The value on `mem_dq_in` in the last of the RD cycles is returned on `resp_rdata`, with `resp_valid`=1 for exactly the one cycle that follows.
- R5: After the RD cycles, `mem_ce_n` and `mem_oe_n` are both 1 for REL cycles (REL ≥ 1, the output-off time after output-enable rises) before `req_ready` returns. This means a write can never begin while the memory may still drive the bus.
- R6: A write (`req_write`=1) holds `mem_ce_n`=0 and `mem_we_n`=0 for FLT+DRV consecutive cycles starting in the cycle after acceptance. `mem_oe_n` stays 1 throughout.
- R7: During a write, `mem_dq_oe` is 0 for the first FLT cycles of the strobe (FLT is the memory's output-off time after the strobe falls). It is 1 for the remaining DRV cycles, with `mem_dq_out` equal to the accepted write data. It returns to 0 in the same cycle that `mem_we_n` returns to 1.
- R8: A write produces no `resp_valid` pulse.
- R9: `mem_addr` equals the accepted request address and does not change during any cycle in which `mem_ce_n` is 0.
- R10: Each phase length is the ceiling of its nanosecond figure divided by the clock period, and never less than 1. DRV is the largest of:
  - the data-setup count;
  - the strobe-pulse count minus FLT;
  - the address-to-end count minus FLT;
  - the write-cycle count minus FLT;
  - 1.
  With the defaults (4 ns clock, figures 10/5/5/4/10/5/8/10 ns) this gives RD=3, REL=2, FLT=1 and DRV=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| resp_valid | output | 1 | One-cycle strobe qualifying read data |
| resp_rdata | output | 8 | Captured read data |
| mem_addr | output | 15 | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 8 | Data the controller drives onto the bus |
| mem_dq_oe | output | 1 | Controller bus-driver enable, active high |
| mem_dq_in | input | 8 | Data seen on the bus |

## Verification
Reads of never-written addresses at both ends of the space return a value computed from the address. These reads, set against later readback of written data, separate data captured from the bus from data left stale in the controller. The bus model presents correct data only in the final access cycle and the bitwise complement before it, so a capture taken one cycle early is exposed. Requests held valid through busy periods are used to tell accepted requests from ignored ones:
- back-to-back writes;
- a write whose valid line stays high with a different address and data during the busy cycles;
- a read followed at once by a write.

A long address-aliased mixed sequence compares every pin on every cycle against a schedule-based model.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_RD_REL   = 3'd2,
    ST_WR_FLOAT = 3'd3,
    ST_WR_DRIVE = 3'd4
  } seq_state_e;

  // Whole clock cycles covering a span, never less than one.
  function automatic int cycles_for(input int span_ps, input int clk_ps);
    int c;
    c = (span_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Remainder of a span once an earlier phase is subtracted, floor of one.
  function automatic int left_after(input int total, input int used);
    return (total > used) ? (total - used) : 1;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expired = (remain_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_port_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int RD_C  = 3,
  parameter int REL_C = 2,
  parameter int FLT_C = 1,
  parameter int DRV_C = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             fire_write,
  input  logic             expired,
  output seq_state_e       state,
  output seq_state_e       state_nxt,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             capture
);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_C - 1);
  localparam logic [CNT_W-1:0] REL_LD = CNT_W'(REL_C - 1);
  localparam logic [CNT_W-1:0] FLT_LD = CNT_W'(FLT_C - 1);
  localparam logic [CNT_W-1:0] DRV_LD = CNT_W'(DRV_C - 1);

  seq_state_e state_q;

  always_comb begin
    state_nxt = state_q;
    load      = 1'b0;
    load_val  = '0;
    capture   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (fire) begin
          load = 1'b1;
          if (fire_write) begin
            state_nxt = ST_WR_FLOAT;
            load_val  = FLT_LD;
          end else begin
            state_nxt = ST_RD_ACC;
            load_val  = RD_LD;
          end
        end
      end
      ST_RD_ACC: begin
        if (expired) begin
          capture   = 1'b1;
          load      = 1'b1;
          load_val  = REL_LD;
          state_nxt = ST_RD_REL;
        end
      end
      ST_RD_REL: begin
        if (expired) state_nxt = ST_IDLE;
      end
      ST_WR_FLOAT: begin
        if (expired) begin
          load      = 1'b1;
          load_val  = DRV_LD;
          state_nxt = ST_WR_DRIVE;
        end
      end
      ST_WR_DRIVE: begin
        if (expired) state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_nxt;
  end

  assign state = state_q;
endmodule

// File: rtl/sram_bus_path.sv
module sram_bus_path
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state_nxt,
  input  logic              fire,
  input  logic [ADDR_W-1:0] fire_addr,
  input  logic [DATA_W-1:0] fire_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_pins,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  logic ce_d, oe_d, we_d, drv_d;
  logic ce_q, oe_q, we_q, drv_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  // Pin levels for the state about to be entered; registered so pins never glitch.
  always_comb begin
    ce_d  = 1'b1;
    oe_d  = 1'b1;
    we_d  = 1'b1;
    drv_d = 1'b0;
    case (state_nxt)
      ST_RD_ACC: begin
        ce_d = 1'b0;
        oe_d = 1'b0;
      end
      ST_WR_FLOAT: begin
        ce_d = 1'b0;
        we_d = 1'b0;
      end
      ST_WR_DRIVE: begin
        ce_d  = 1'b0;
        we_d  = 1'b0;
        drv_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q     <= 1'b1;
      oe_q     <= 1'b1;
      we_q     <= 1'b1;
      drv_q    <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      ce_q     <= ce_d;
      oe_q     <= oe_d;
      we_q     <= we_d;
      drv_q    <= drv_d;
      rvalid_q <= capture;
      if (fire) begin
        addr_q  <= fire_addr;
        wdata_q <= fire_wdata;
      end
      if (capture) rdata_q <= dq_in;
    end
  end

  assign addr_pins = addr_q;
  assign ce_n      = ce_q;
  assign oe_n      = oe_q;
  assign we_n      = we_q;
  assign dq_oe     = drv_q;
  assign dq_out    = wdata_q;
  assign rvalid    = rvalid_q;
  assign rdata     = rdata_q;
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PS        = 4000,
  parameter int T_ADDR_ACC_PS = 10000,
  parameter int T_OE_ACC_PS   = 5000,
  parameter int T_OE_OFF_PS   = 5000,
  parameter int T_WE_OFF_PS   = 4000,
  parameter int T_WE_PULSE_PS = 10000,
  parameter int T_DATA_SU_PS  = 5000,
  parameter int T_ADDR_SU_PS  = 8000,
  parameter int T_WR_CYC_PS   = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int RD_C  = max_of(cycles_for(T_ADDR_ACC_PS, CLK_PS),
                                cycles_for(T_OE_ACC_PS, CLK_PS));
  localparam int REL_C = cycles_for(T_OE_OFF_PS, CLK_PS);
  localparam int FLT_C = cycles_for(T_WE_OFF_PS, CLK_PS);
  localparam int DRV_C = max_of(
      max_of(cycles_for(T_DATA_SU_PS, CLK_PS),
             left_after(cycles_for(T_WE_PULSE_PS, CLK_PS), FLT_C)),
      max_of(left_after(cycles_for(T_ADDR_SU_PS, CLK_PS), FLT_C),
             left_after(cycles_for(T_WR_CYC_PS, CLK_PS), FLT_C)));
  localparam int LONGEST = max_of(max_of(RD_C, REL_C), max_of(FLT_C, DRV_C));
  localparam int CNT_W   = $clog2(LONGEST + 1);

  seq_state_e       state, state_nxt;
  logic             fire, expired, load, capture;
  logic [CNT_W-1:0] load_val;

  assign req_ready = (state == ST_IDLE);
  assign fire      = req_valid && req_ready;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  sram_seq_fsm #(
    .CNT_W (CNT_W),
    .RD_C  (RD_C),
    .REL_C (REL_C),
    .FLT_C (FLT_C),
    .DRV_C (DRV_C)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .fire_write (req_write),
    .expired    (expired),
    .state      (state),
    .state_nxt  (state_nxt),
    .load       (load),
    .load_val   (load_val),
    .capture    (capture)
  );

  sram_bus_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk        (clk),
    .rst        (rst),
    .state_nxt  (state_nxt),
    .fire       (fire),
    .fire_addr  (req_addr),
    .fire_wdata (req_wdata),
    .capture    (capture),
    .dq_in      (mem_dq_in),
    .addr_pins  (mem_addr),
    .ce_n       (mem_ce_n),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .dq_out     (mem_dq_out),
    .dq_oe      (mem_dq_oe),
    .rvalid     (resp_valid),
    .rdata      (resp_rdata)
  );
endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_read_strobe_high_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  assert_resp_follows_access_R4: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ($past(!mem_oe_n) && mem_oe_n));

  assert_turnaround_before_write_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(mem_oe_n));

  assert_write_oe_high_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  assert_drive_after_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> $past(!mem_we_n));

  assert_release_with_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !mem_we_n);

  assert_no_resp_in_write_R8: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !resp_valid);

  assert_addr_steady_R9: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_port_ctrl_test.sv
module sram_port_ctrl_test;
  localparam int PERIOD = 4;
  localparam int HALF   = PERIOD / 2;

  function automatic int ceil_cyc(input int ns);
    int c;
    c = (ns + PERIOD - 1) / PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R10: phase lengths from the nanosecond figures
  localparam int RD  = imax(ceil_cyc(10), ceil_cyc(5));
  localparam int REL = ceil_cyc(5);
  localparam int FLT = ceil_cyc(4);
  localparam int DRV = imax(imax(ceil_cyc(5), ceil_cyc(10) - FLT),
                            imax(imax(ceil_cyc(8) - FLT, ceil_cyc(10) - FLT), 1));

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  mem_dq_in = '0;
  logic        req_ready, resp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  resp_rdata, mem_dq_out;
  logic [14:0] mem_addr;

  sram_port_ctrl #(.CLK_PS(PERIOD * 1000)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  always #HALF clk = ~clk;

  typedef struct {
    bit    ce, oe, we, drv, resp;
    string tag;
  } slot_t;

  slot_t       sched[$];
  logic [7:0]  gold[int];
  logic [7:0]  pinmem[int];
  int          tests = 0, fails = 0;
  bit          model_idle = 1'b0;
  bit          finished = 1'b0;
  logic [14:0] cur_addr = '0;
  logic [7:0]  cur_wdata = '0, cur_rexp = '0;
  bit          last_drive = 1'b0;
  logic [14:0] last_a = '0;
  logic [7:0]  last_d = '0;
  int          acc_run = 0;

  function automatic logic [7:0] seed_val(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
  endfunction
  function automatic logic [7:0] gold_rd(input logic [14:0] a);
    return gold.exists(int'(a)) ? gold[int'(a)] : seed_val(a);
  endfunction
  function automatic logic [7:0] pin_rd(input logic [14:0] a);
    return pinmem.exists(int'(a)) ? pinmem[int'(a)] : seed_val(a);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push_slot(input bit ce, input bit oe, input bit we,
                           input bit drv, input bit resp, input string tag);
    slot_t s;
    s.ce = ce; s.oe = oe; s.we = we; s.drv = drv; s.resp = resp; s.tag = tag;
    sched.push_back(s);
  endtask

  task automatic tick();
    slot_t e;
    @(negedge clk);
    // Model the edge just passed: accept only when idle and out of reset.
    if (!rst && req_valid && model_idle) begin
      cur_addr  = req_addr;
      cur_wdata = req_wdata;
      if (req_write) begin
        gold[int'(req_addr)] = req_wdata;
        for (int k = 0; k < FLT; k++) push_slot(0, 1, 0, 0, 0, "R6");
        for (int k = 0; k < DRV; k++) push_slot(0, 1, 0, 1, 0, "R7");
      end else begin
        cur_rexp = gold_rd(req_addr);
        for (int k = 0; k < RD; k++)  push_slot(0, 0, 1, 0, 0, "R3/R10");
        for (int k = 0; k < REL; k++) push_slot(1, 1, 1, 0, (k == 0), "R5");
      end
    end
    if (sched.size() > 0) begin
      e = sched.pop_front();
      model_idle = 1'b0;
    end else begin
      e.ce = 1; e.oe = 1; e.we = 1; e.drv = 0; e.resp = 0; e.tag = "R1";
      model_idle = 1'b1;
    end
    chk(model_idle ? "R1" : "R2", "req_ready", req_ready, model_idle);
    chk(e.tag, "mem_ce_n", mem_ce_n, e.ce);
    chk(e.tag, "mem_oe_n", mem_oe_n, e.oe);
    chk(e.tag, "mem_we_n", mem_we_n, e.we);
    chk(e.tag, "mem_dq_oe", mem_dq_oe, e.drv);
    chk(e.resp ? "R4" : "R8", "resp_valid", resp_valid, e.resp);
    if (!e.ce) chk("R9", "mem_addr", mem_addr, cur_addr);
    if (e.drv) chk("R7", "mem_dq_out", mem_dq_out, cur_wdata);
    if (e.resp) chk("R4", "resp_rdata", resp_rdata, cur_rexp);
    // Pin-level memory: commit on the strobe's rising edge.
    if (last_drive && mem_we_n) pinmem[int'(last_a)] = last_d;
    last_drive = !mem_we_n && !mem_ce_n && mem_dq_oe;
    last_a = mem_addr;
    last_d = mem_dq_out;
    // Data only valid in the RD-th access cycle; complement before it.
    if (!mem_ce_n && !mem_oe_n) acc_run++;
    else acc_run = 0;
    mem_dq_in = (acc_run >= RD) ? pin_rd(mem_addr) : ~pin_rd(mem_addr);
  endtask

  task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d,
                       input bit noise);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!model_idle) tick();
    tick();
    if (noise) begin
      req_write = 1'b1; req_addr = 15'h1234; req_wdata = 8'hFF;
    end else begin
      req_valid = 1'b0;
    end
    while (sched.size() > 0) tick();
    req_valid = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: act=hung exp=complete");
    summary();
  end

  initial begin
    int unsigned s;
    logic [14:0] a;
    // R1: request held during reset must be ignored
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0005; req_wdata = 8'h77;
    repeat (4) tick();
    rst = 1'b0; req_valid = 1'b0;
    tick();
    issue(0, 15'h0005, 8'h00, 0);      // R1: reset-time write absent
    issue(0, 15'h0000, 8'h00, 0);      // R3/R4 low end
    issue(0, 15'h7FFF, 8'h00, 0);      // R3/R4 high end
    issue(1, 15'h0000, 8'hA5, 0);      // R6/R7
    issue(1, 15'h7FFF, 8'h5A, 1);      // R2: noise during busy
    issue(0, 15'h1234, 8'h00, 0);      // R2: noise never written
    issue(0, 15'h0000, 8'h00, 0);
    issue(0, 15'h7FFF, 8'h00, 0);
    issue(0, 15'h0040, 8'h00, 0);      // R5: read then write at once
    issue(1, 15'h0040, 8'hC3, 0);
    issue(0, 15'h0040, 8'h00, 0);
    s = 32'h1ACE;
    for (int i = 0; i < 64; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      a = 15'((s >> 16) & 15) * 15'h0811;
      issue(s[9], a, s[27:20], s[5] & s[6]);
    end
    repeat (3) tick();
    summary();
  end
endmodule